// File: doc/BRIEF.md
# Signed One-Digit Seven-Segment Driver

This block takes a 4-bit ones' complement number and shows it on a single seven-segment digit. The decimal point serves as a minus sign. The top bit of the input is the sign. The three lower bits are XORed with that sign, so a negative code turns into its magnitude. The magnitude then goes to a BCD-to-segment decoder whose top BCD input is held at zero, which means only the digits 0 to 7 can ever be shown.

All display lines are active low: a 0 on a line lights that segment or the point. The segment and point outputs are registered, so a code sampled at one rising clock edge appears on the outputs right after that edge. A synchronous active-high reset blanks the whole digit. The code 1111, negative zero, shows a 0 with the minus point lit. This is intended and is not suppressed.

Top module: `sm7_driver`

## Requirements
- R1: While `rst` is high at a rising edge, every segment line and the point line go to 1 (dark) after that edge, whatever the code on `res_i`.
- R2: Outputs are registered with one cycle of latency: after a rising edge with `rst` low, they show the code that `res_i` held at that edge, and they keep it until the next edge.
- R3: Bit 3 of `res_i` is the sign. When it is 0, the digit shown is the value of bits 2..0 and `dp_n_o` is 1 (point dark).
- R4: When bit 3 is 1, the digit shown is the bitwise inverse of bits 2..0 (for example 1010 shows 5).
- R5: `dp_n_o` is 0 (minus lit) exactly when bit 3 of the sampled code was 1.
- R6: `seg_n_o` uses bit order {g,f,e,d,c,b,a}, active low, with these patterns: 0=1000000, 1=1111001, 2=0100100, 3=0110000, 4=0011001, 5=0010010, 6=0000010, 7=1111000.
- R7: Code 1111 shows the 0 pattern with `dp_n_o`=0. Code 0000 shows the 0 pattern with `dp_n_o`=1.
- R8: Out of reset, `seg_n_o` only ever holds one of the eight patterns of R6; the patterns for 8 and 9 never appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| res_i | input | 4 | Ones' complement code; bit 3 is the sign |
| seg_n_o | output | 7 | Segment lines {g,f,e,d,c,b,a}, active low |
| dp_n_o | output | 1 | Minus-sign point, active low |

## Verification
The sign bit does two jobs in the same cycle: it inverts the magnitude path and it lights the minus point. Both results must come from the same sampled code and appear after the same edge. The bench drives every code, including the two zero codes, and checks segments and point together one cycle later. It also raises reset in the same cycle that a negative code arrives, and expects the blank state to win over both paths.

// File: rtl/sm7_pkg.sv
package sm7_pkg;
  localparam int SEG_W = 7;
  localparam int BCD_W = 4;
  typedef logic [SEG_W-1:0] seg_t;
  localparam seg_t SEG_BLANK = '1;
endpackage

// File: rtl/sm7_sign_split.sv
module sm7_sign_split #(
  parameter int RES_W = 4,
  localparam int MAG_W = RES_W - 1
) (
  input  logic [RES_W-1:0] code_i,
  output logic             neg_o,
  output logic [MAG_W-1:0] mag_o
);
  assign neg_o = code_i[RES_W-1];
  for (genvar i = 0; i < MAG_W; i++) begin : g_flip
    assign mag_o[i] = code_i[i] ^ code_i[RES_W-1];
  end
endmodule

// File: rtl/sm7_seg_decode.sv
module sm7_seg_decode
  import sm7_pkg::*;
(
  input  logic [BCD_W-1:0] bcd_i,
  output seg_t             seg_n_o
);
  always_comb begin
    unique case (bcd_i)
      4'd0:    seg_n_o = 7'b1000000;
      4'd1:    seg_n_o = 7'b1111001;
      4'd2:    seg_n_o = 7'b0100100;
      4'd3:    seg_n_o = 7'b0110000;
      4'd4:    seg_n_o = 7'b0011001;
      4'd5:    seg_n_o = 7'b0010010;
      4'd6:    seg_n_o = 7'b0000010;
      4'd7:    seg_n_o = 7'b1111000;
      4'd8:    seg_n_o = 7'b0000000;
      4'd9:    seg_n_o = 7'b0010000;
      default: seg_n_o = SEG_BLANK;
    endcase
  end
endmodule

// File: rtl/sm7_driver.sv
module sm7_driver
  import sm7_pkg::*;
#(
  parameter int RES_W = 4,
  localparam int MAG_W = RES_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RES_W-1:0] res_i,
  output logic [SEG_W-1:0] seg_n_o,
  output logic             dp_n_o
);
  logic             neg;
  logic [MAG_W-1:0] mag;
  logic [BCD_W-1:0] bcd;
  seg_t             seg_d;

  sm7_sign_split #(.RES_W(RES_W)) split_i (
    .code_i (res_i),
    .neg_o  (neg),
    .mag_o  (mag)
  );

  // top BCD input held at zero: only 0..7 reach the decoder
  assign bcd = {{(BCD_W-MAG_W){1'b0}}, mag};

  sm7_seg_decode dec_i (
    .bcd_i   (bcd),
    .seg_n_o (seg_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_n_o <= SEG_BLANK;
      dp_n_o  <= 1'b1;
    end else begin
      seg_n_o <= seg_d;
      dp_n_o  <= ~neg;
    end
  end
endmodule

// File: rtl/sm7_driver_chk.sv
module sm7_driver_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] res_i,
  input logic [6:0] seg_n_o,
  input logic       dp_n_o
);
  AST_RESET_BLANK: assert property (@(posedge clk) rst |=> (seg_n_o == 7'h7F && dp_n_o)); // R1
  AST_MINUS_POINT: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (dp_n_o == !$past(res_i[3]))); // R5
  AST_LEGAL_GLYPH: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (seg_n_o inside {7'b1000000, 7'b1111001, 7'b0100100, 7'b0110000,
                              7'b0011001, 7'b0010010, 7'b0000010, 7'b1111000})); // R8
  AST_NEG_ZERO: assert property (@(posedge clk) disable iff (rst)
    (res_i == 4'hF) |=> (seg_n_o == 7'b1000000 && !dp_n_o)); // R7
  AST_POS_SEVEN: assert property (@(posedge clk) disable iff (rst)
    (res_i == 4'h7) |=> (seg_n_o == 7'b1111000 && dp_n_o)); // R3
endmodule

bind sm7_driver sm7_driver_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .res_i   (res_i),
  .seg_n_o (seg_n_o),
  .dp_n_o  (dp_n_o)
);

// File: tb/sm7_driver_tb_top.sv
module sm7_driver_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] res_i = 4'h0;
  logic [6:0] seg_n_o;
  logic       dp_n_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sm7_driver dut_i (
    .clk     (clk),
    .rst     (rst),
    .res_i   (res_i),
    .seg_n_o (seg_n_o),
    .dp_n_o  (dp_n_o)
  );

  // {code, expected segments, expected point}
  localparam logic [11:0] VEC [16] = '{
    {4'h0, 7'b1000000, 1'b1}, {4'h1, 7'b1111001, 1'b1},
    {4'h2, 7'b0100100, 1'b1}, {4'h3, 7'b0110000, 1'b1},
    {4'h4, 7'b0011001, 1'b1}, {4'h5, 7'b0010010, 1'b1},
    {4'h6, 7'b0000010, 1'b1}, {4'h7, 7'b1111000, 1'b1},
    {4'h8, 7'b1111000, 1'b0}, {4'h9, 7'b0000010, 1'b0},
    {4'hA, 7'b0010010, 1'b0}, {4'hB, 7'b0011001, 1'b0},
    {4'hC, 7'b0110000, 1'b0}, {4'hD, 7'b0100100, 1'b0},
    {4'hE, 7'b1111001, 1'b0}, {4'hF, 7'b1000000, 1'b0}
  };

  task automatic check(input string req, input logic [6:0] es, input logic ep);
    checks++;
    if (seg_n_o !== es || dp_n_o !== ep) begin
      errors++;
      $display("FAIL %s: seg=%b dp=%b expected seg=%b dp=%b", req, seg_n_o, dp_n_o, es, ep);
    end
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    res_i = 4'hB;
    repeat (2) @(negedge clk);
    check("R1 reset blank", 7'h7F, 1'b1);
    rst = 1'b0;
    // exhaustive walk: R3 R4 R5 R6 R7
    for (int i = 0; i < 16; i++) begin
      res_i = VEC[i][11:8];
      @(negedge clk);
      check(i[3] ? "R4/R5/R6 negative code" : "R3/R6 positive code", VEC[i][7:1], VEC[i][0]);
    end
    // R7 both zeros
    res_i = 4'hF; @(negedge clk);
    check("R7 negative zero", 7'b1000000, 1'b0);
    res_i = 4'h0; @(negedge clk);
    check("R7 positive zero", 7'b1000000, 1'b1);
    // R2 latency: change input mid-cycle, output holds until the edge
    res_i = 4'h3; @(negedge clk);
    res_i = 4'hA; #1;
    check("R2 hold before edge", 7'b0110000, 1'b1);
    @(negedge clk);
    check("R2 update after edge", 7'b0010010, 1'b0);
    // R1: reset wins over a negative code in the same cycle
    res_i = 4'h9; rst = 1'b1; @(negedge clk);
    check("R1 reset over negative code", 7'h7F, 1'b1);
    rst = 1'b0; @(negedge clk);
    check("R2 resume after reset", 7'b0000010, 1'b0);
    // R8: ones' complement of 8/9 shapes never show; 0111 gives 7, 1000 gives 7
    res_i = 4'h8; @(negedge clk);
    check("R8 no digit above 7", 7'b1111000, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule